// File: doc/BRIEF.md
# Paged program counter

This block holds the fetch address of a small 8-bit controller whose program memory is up to 8 KB. The address is 13 bits wide and is kept as two parts: an 8-bit offset inside a 256-byte page, and a 5-bit page number. Sequential execution moves only the offset. When the offset passes the end of a page it wraps to the start of the same page. Code moves to the next page only when a dedicated page-advance instruction tells it to.

The fetch stage reports each instruction it retires with a step strobe and a length of one or two bytes. A page-advance strobe moves the page number up by one. Jumps and calls load a full 13-bit target. A return loads the full 13-bit address popped from the return stack. Firmware cannot read or write the counter except through these paths. The block also drives the address of the next sequential instruction on a separate output, so the stack logic can save it on a call or an interrupt.

Top module: `paged_pc`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` is 0x0000, so the first fetch after reset is at address zero.
- R2: With `step_en` high and no load or restore, the offset (`fetch_addr[7:0]`) grows by 1 when `step_len` is 0 and by 2 when `step_len` is 1, at the next rising clock edge.
- R3: The offset addition is modulo 256. Any carry out of bit 7 is dropped and never reaches the page number (`fetch_addr[12:8]`).
- R4: The page number changes only on a cycle with `page_adv` high and no load or restore. It then grows by one, and it wraps from 31 to 0. On other sequential cycles it holds its value.
- R5: `load_en` replaces all 13 bits with `load_addr` at the next edge. It has priority over restore, step and page advance.
- R6: `ret_en` without `load_en` replaces all 13 bits with `ret_addr` at the next edge. It wins over `page_adv` and `step_en` in the same cycle.
- R7: `next_addr` is combinational and always equals the current page followed by (offset + length) modulo 256, where the length is 1 or 2 as selected by `step_len`.
- R8: A cycle with no strobe high leaves `fetch_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | An instruction retired; advance the offset |
| step_len | input | 1 | Instruction length: 0 = one byte, 1 = two bytes |
| page_adv | input | 1 | Page-advance instruction executed |
| load_en | input | 1 | Load a jump or call target |
| load_addr | input | 13 | Jump or call target |
| ret_en | input | 1 | Restore from the return stack |
| ret_addr | input | 13 | Address popped from the return stack |
| fetch_addr | output | 13 | Current fetch address |
| next_addr | output | 13 | Address of the next sequential instruction |

## Verification
The bench steps the offset to 0xFF with both instruction lengths. A design that let the carry ripple into the page number would show the wrong page there, and a two-byte step from 0xFF must land on offset 0x01. The page number is taken through 31 to check that it wraps to zero and does not saturate. The bench also raises the strobes together, in load, restore and page-advance combinations. A design with the wrong priority would take a step or a page advance on top of the loaded or restored address, or would let the restore override a jump.

// File: rtl/pgpc_pkg.sv
package pgpc_pkg;
  localparam int OFS_W  = 8;
  localparam int PAGE_W = 5;
  localparam int ADDR_W = OFS_W + PAGE_W;

  typedef enum logic [1:0] {
    PC_HOLD    = 2'd0,
    PC_SEQ     = 2'd1,
    PC_JUMP    = 2'd2,
    PC_RESTORE = 2'd3
  } pc_mode_e;

  // offset advance inside a page: carry out of the top bit is dropped
  function automatic logic [OFS_W-1:0] ofs_advance(input logic [OFS_W-1:0] ofs,
                                                   input logic two_byte);
    logic [OFS_W-1:0] inc;
    inc = two_byte ? OFS_W'(2) : OFS_W'(1);
    return ofs + inc;
  endfunction

  // page advance: wraps at the top page
  function automatic logic [PAGE_W-1:0] page_advance(input logic [PAGE_W-1:0] pg);
    return pg + PAGE_W'(1);
  endfunction
endpackage

// File: rtl/pgpc_sel.sv
module pgpc_sel
  import pgpc_pkg::*;
(
  input  logic     load_en,
  input  logic     ret_en,
  input  logic     step_en,
  input  logic     page_adv,
  output pc_mode_e mode,
  output logic     do_load,
  output logic     do_ret,
  output logic     do_step,
  output logic     do_page
);
  always_comb begin
    if (load_en)                 mode = PC_JUMP;
    else if (ret_en)             mode = PC_RESTORE;
    else if (step_en | page_adv) mode = PC_SEQ;
    else                         mode = PC_HOLD;
  end

  assign do_load = (mode == PC_JUMP);
  assign do_ret  = (mode == PC_RESTORE);
  assign do_step = (mode == PC_SEQ) & step_en;
  assign do_page = (mode == PC_SEQ) & page_adv;
endmodule

// File: rtl/pgpc_ofs_ctr.sv
module pgpc_ofs_ctr
  import pgpc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_load,
  input  logic             do_ret,
  input  logic             do_step,
  input  logic             two_byte,
  input  logic [OFS_W-1:0] load_ofs,
  input  logic [OFS_W-1:0] ret_ofs,
  output logic [OFS_W-1:0] ofs_q,
  output logic [OFS_W-1:0] ofs_next
);
  assign ofs_next = ofs_advance(ofs_q, two_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ofs_q <= '0;
    else if (do_load) ofs_q <= load_ofs;
    else if (do_ret)  ofs_q <= ret_ofs;
    else if (do_step) ofs_q <= ofs_next;
  end
endmodule

// File: rtl/pgpc_page_ctr.sv
module pgpc_page_ctr
  import pgpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_load,
  input  logic              do_ret,
  input  logic              do_page,
  input  logic [PAGE_W-1:0] load_pg,
  input  logic [PAGE_W-1:0] ret_pg,
  output logic [PAGE_W-1:0] pg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pg_q <= '0;
    else if (do_load) pg_q <= load_pg;
    else if (do_ret)  pg_q <= ret_pg;
    else if (do_page) pg_q <= page_advance(pg_q);
  end
endmodule

// File: rtl/paged_pc.sv
module paged_pc
  import pgpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic              step_len,
  input  logic              page_adv,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              ret_en,
  input  logic [ADDR_W-1:0] ret_addr,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] next_addr
);
  pc_mode_e          ev_mode;
  logic              ev_load, ev_ret, ev_step, ev_page;
  logic [OFS_W-1:0]  ofs_q, ofs_next;
  logic [PAGE_W-1:0] pg_q;

  pgpc_sel u_sel (
    .load_en (load_en),  .ret_en  (ret_en),
    .step_en (step_en),  .page_adv(page_adv),
    .mode    (ev_mode),
    .do_load (ev_load),  .do_ret  (ev_ret),
    .do_step (ev_step),  .do_page (ev_page)
  );

  pgpc_ofs_ctr u_ofs (
    .clk     (clk),      .rst_n   (rst_n),
    .do_load (ev_load),  .do_ret  (ev_ret),
    .do_step (ev_step),  .two_byte(step_len),
    .load_ofs(load_addr[OFS_W-1:0]),
    .ret_ofs (ret_addr[OFS_W-1:0]),
    .ofs_q   (ofs_q),    .ofs_next(ofs_next)
  );

  pgpc_page_ctr u_page (
    .clk     (clk),      .rst_n   (rst_n),
    .do_load (ev_load),  .do_ret  (ev_ret),
    .do_page (ev_page),
    .load_pg (load_addr[ADDR_W-1:OFS_W]),
    .ret_pg  (ret_addr[ADDR_W-1:OFS_W]),
    .pg_q    (pg_q)
  );

  assign fetch_addr = {pg_q, ofs_q};
  assign next_addr  = {pg_q, ofs_next};
endmodule

// File: rtl/pgpc_chk.sv
module pgpc_chk
  import pgpc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              step_len,
  input logic              page_adv,
  input logic              load_en,
  input logic [ADDR_W-1:0] load_addr,
  input logic              ret_en,
  input logic [ADDR_W-1:0] ret_addr,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] next_addr,
  input logic              ev_load,
  input logic              ev_ret,
  input logic              ev_step,
  input logic              ev_page
);
  // R1
  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |-> fetch_addr == '0);

  // R2 and R3: offset moves by the length, modulo 256
  a_r2_r3_ofs_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> fetch_addr[OFS_W-1:0] ==
      OFS_W'($past(fetch_addr[OFS_W-1:0]) + ($past(step_len) ? 2 : 1)));

  // R3 and R4: page holds unless a page advance is taken
  a_r4_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_page && !load_en && !ret_en) |=>
      fetch_addr[ADDR_W-1:OFS_W] == $past(fetch_addr[ADDR_W-1:OFS_W]));

  a_r4_page_inc: assert property (@(posedge clk) disable iff (!rst_n)
    ev_page |=> fetch_addr[ADDR_W-1:OFS_W] ==
      PAGE_W'($past(fetch_addr[ADDR_W-1:OFS_W]) + 1));

  // R5
  a_r5_load_all: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> fetch_addr == $past(load_addr));

  // R6
  a_r6_restore_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !load_en) |=> fetch_addr == $past(ret_addr));

  // R5 and R6: at most one source selected
  a_r6_onehot_src: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_load, ev_ret, ev_step | ev_page}));

  // R7
  a_r7_next_page: assert property (@(posedge clk) disable iff (!rst_n)
    next_addr[ADDR_W-1:OFS_W] == fetch_addr[ADDR_W-1:OFS_W]);

  // R8
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load && !ev_ret && !ev_step && !ev_page) |=> $stable(fetch_addr));
endmodule

bind paged_pc pgpc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .step_len(step_len), .page_adv(page_adv),
  .load_en(load_en), .load_addr(load_addr), .ret_en(ret_en), .ret_addr(ret_addr),
  .fetch_addr(fetch_addr), .next_addr(next_addr),
  .ev_load(ev_load), .ev_ret(ev_ret), .ev_step(ev_step), .ev_page(ev_page)
);

// File: tb/paged_pc_tb.sv
module paged_pc_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_en = 1'b0, step_len = 1'b0, page_adv = 1'b0;
  logic        load_en = 1'b0, ret_en = 1'b0;
  logic [12:0] load_addr = '0, ret_addr = '0;
  logic [12:0] fetch_addr, next_addr;
  int checks = 0, errors = 0;
  logic [12:0] model = '0;

  paged_pc u_dut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_len(step_len),
    .page_adv(page_adv), .load_en(load_en), .load_addr(load_addr),
    .ret_en(ret_en), .ret_addr(ret_addr),
    .fetch_addr(fetch_addr), .next_addr(next_addr)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [12:0] got, input logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // one cycle: drive at negedge, check next_addr, update model, check after edge
  task automatic cyc(input logic st, input logic ln, input logic pa,
                     input logic ld, input logic [12:0] la,
                     input logic rt, input logic [12:0] ra, input string req);
    logic [7:0] o;
    logic [4:0] p;
    step_en = st; step_len = ln; page_adv = pa;
    load_en = ld; load_addr = la; ret_en = rt; ret_addr = ra;
    #1;
    o = model[7:0] + (ln ? 8'd2 : 8'd1);
    check("R7 next_addr", next_addr, {model[12:8], o});
    if (ld) model = la;
    else if (rt) model = ra;
    else begin
      o = model[7:0]; p = model[12:8];
      if (st) o = o + (ln ? 8'd2 : 8'd1);
      if (pa) p = p + 5'd1;
      model = {p, o};
    end
    @(negedge clk);
    check(req, fetch_addr, model);
    step_en = 0; page_adv = 0; load_en = 0; ret_en = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset", fetch_addr, 13'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", fetch_addr, 13'h0000);
  endtask

  task automatic t_steps();
    cyc(1, 0, 0, 0, 0, 0, 0, "R2 one byte");
    cyc(1, 1, 0, 0, 0, 0, 0, "R2 two byte");
    cyc(0, 1, 0, 0, 0, 0, 0, "R8 idle");
  endtask

  task automatic t_wrap();
    cyc(0, 0, 0, 1, 13'h03FE, 0, 0, "R5 load");
    cyc(1, 0, 0, 0, 0, 0, 0, "R2 to FF");
    cyc(1, 0, 0, 0, 0, 0, 0, "R3 wrap no carry");
    cyc(0, 0, 0, 1, 13'h05FF, 0, 0, "R5 load FF");
    cyc(1, 1, 0, 0, 0, 0, 0, "R3 two byte wrap");
  endtask

  task automatic t_page();
    cyc(0, 0, 1, 0, 0, 0, 0, "R4 page adv");
    cyc(1, 0, 1, 0, 0, 0, 0, "R4 page adv with step");
    cyc(0, 0, 0, 1, 13'h1F10, 0, 0, "R5 load top page");
    cyc(0, 0, 1, 0, 0, 0, 0, "R4 page wrap 31 to 0");
  endtask

  task automatic t_priority();
    cyc(1, 1, 1, 0, 0, 1, 13'h0ABC, "R6 restore beats step and page");
    cyc(1, 0, 1, 1, 13'h1234, 1, 13'h0777, "R5 load beats all");
    cyc(0, 0, 0, 0, 0, 1, 13'h1FFF, "R6 restore all bits");
    cyc(0, 0, 0, 0, 0, 0, 0, "R8 hold");
  endtask

  initial begin
    t_reset();
    t_steps();
    t_wrap();
    t_page();
    t_priority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog got=%h exp=done", fetch_addr);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule